// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block is the master side of a serial slave-configuration link to a target FPGA. A one-cycle start pulse launches a complete load. The block first pulls the target's reset and chip-select low and holds them, then releases reset and waits for a settle time. It then raises chip-select and sends a run of dummy clocks. Next it lowers chip-select and shifts the bitstream out, taken from a byte stream. Finally it raises chip-select again, sends a second run of dummy clocks, and samples the target's done flag to decide between success and failure.

Bitstream bytes enter on a valid/ready stream with a last marker. The block raises ready only when it sits at a byte boundary in the data phase, with the serial clock high and chip-select low. A byte moves on any cycle where valid and ready are both high. When valid stays low, the block waits indefinitely. During that wait the serial clock stays high and the data line keeps its last bit, so the target sees no edge. There is no timeout on the stream.

Delays come from parameters that give the system clock frequency, the reset hold time, the settle time and the serial clock rate. These are turned into cycle counts, and every interval is timed by one shared down-counter. Control and status pins are plain levels.

Top module: `cfgseq_top`

## Requirements
- R1: On start, `tgt_rst_n` and `tgt_cs_n` fall together in the same cycle, and `tgt_rst_n` stays low for exactly RST_CYC system clock cycles, with `tgt_cs_n` low throughout.
- R2: If `tgt_done` reads high in the last cycle of the reset hold, the load ends in failure. `tgt_rst_n` and `tgt_cs_n` both go high, and no serial clock edge and no stream handshake occur.
- R3: After reset is released, `tgt_rst_n` is high and `tgt_cs_n` is low for exactly SETTLE_CYC cycles before any serial clock activity.
- R4: Exactly LEAD_CLKS rising edges of `tgt_sclk` occur with `tgt_cs_n` high before the first data bit.
- R5: Every accepted byte is sent as 8 rising edges of `tgt_sclk` with `tgt_cs_n` low. The bit on `tgt_mosi` at each rising edge is the byte's bit 7 first, down to bit 0 last.
- R6: `tgt_sclk` idles high. Each low half lasts exactly HALF_CYC cycles. `tgt_mosi` changes only in the cycle where `tgt_sclk` falls, never while it stays high.
- R7: After the byte marked last, `tgt_cs_n` rises and exactly TRAIL_CLKS rising edges of `tgt_sclk` follow with `tgt_cs_n` high.
- R8: After the trailing clocks, `load_ok` goes high if `tgt_done` reads high, and `load_fail` goes high otherwise. The two flags are never high together, and both hold until the next start.
- R9: Out of reset and after any load ends, `tgt_rst_n`, `tgt_cs_n` and `tgt_sclk` are high and `busy` is low.
- R10: `byte_ready` is high only with `tgt_sclk` high and `tgt_cs_n` low, between bytes of the data phase. While the stream stalls, `tgt_mosi` keeps the last bit sent.
- R11: `busy` is high from the cycle after start until the cycle the result flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load when idle |
| byte_valid | input | 1 | Bitstream byte present |
| byte_data | input | 8 | Bitstream byte |
| byte_last | input | 1 | Marks the final byte of the image |
| byte_ready | output | 1 | Byte accepted this cycle when valid is also high |
| tgt_done | input | 1 | Target's configuration-done flag |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_sclk | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load completed with done high |
| load_fail | output | 1 | Last load failed (done early or missing) |

## Verification
The hardest situation to reach is a stream that stalls partway through an image. That is the only time the data line must hold a bit while the clock sits high for many cycles. The bench gets there with a byte-feeding process that inserts idle gaps of different lengths between bytes, taken from a table of runs. It compares the data line against the last captured bit on every ready cycle. It also reaches the early-done failure, which a well-behaved target never produces, by holding the done input high through the reset hold. It resets the block in the middle of a data phase to check that the lines return high.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTHOLD,
    ST_SETTLE,
    ST_LEAD,
    ST_WAIT,
    ST_SHIFT,
    ST_TRAIL
  } seq_state_e;
endpackage

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // the counter never wraps below zero
  p_timer_nowrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));
endmodule

// File: rtl/cfgseq_runcnt.sv
module cfgseq_runcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/cfgseq_serializer.sv
module cfgseq_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          shift,
  output logic          mosi,
  output logic          empty
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic          mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      sh_q   <= din;
      idx_q  <= IW'(DW - 1);
      mosi_q <= din[DW-1];
    end else if (shift) begin
      sh_q   <= sh_q << 1;
      idx_q  <= idx_q - 1'b1;
      mosi_q <= sh_q[DW-2];
    end
  end

  assign mosi  = mosi_q;
  assign empty = (idx_q == '0);

  // data moves only on load or shift
  p_mosi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && !$past(shift) |-> $stable(mosi_q));
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int RST_HOLD_NS = 1000,
  parameter int SETTLE_US   = 1200,
  parameter int SCLK_KHZ    = 10000,
  parameter int LEAD_CLKS   = 8,
  parameter int TRAIL_CLKS  = 49
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  output logic       byte_ready,
  input  logic       tgt_done,
  output logic       tgt_rst_n,
  output logic       tgt_cs_n,
  output logic       tgt_sclk,
  output logic       tgt_mosi,
  output logic       busy,
  output logic       load_ok,
  output logic       load_fail
);
  localparam int RST_CYC    = (RST_HOLD_NS * CLK_MHZ + 999) / 1000;
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int HALF_CYC   = (CLK_MHZ * 1000) / (2 * SCLK_KHZ);
  localparam int MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_CYC    = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int CW         = 8;

  seq_state_e st_q, st_d;
  logic rstn_q, rstn_d, cs_q, cs_d, sclk_q, sclk_d;
  logic ok_q, ok_d, fail_q, fail_d, last_q, last_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          cnt_load, cnt_dec, cnt_last;
  logic [CW-1:0] cnt_val;
  logic          ser_load, ser_shift, ser_empty, ser_mosi;

  cfgseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  cfgseq_runcnt #(.W(CW)) u_runcnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  cfgseq_serializer #(.DW(8)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .din(byte_data),
    .shift(ser_shift), .mosi(ser_mosi), .empty(ser_empty)
  );

  always_comb begin
    st_d      = st_q;
    rstn_d    = rstn_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    ok_d      = ok_q;
    fail_d    = fail_q;
    last_d    = last_q;
    tmr_load  = 1'b0;
    tmr_val   = TW'(HALF_CYC - 1);
    cnt_load  = 1'b0;
    cnt_val   = CW'(LEAD_CLKS);
    cnt_dec   = 1'b0;
    ser_load  = 1'b0;
    ser_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d     = ST_RSTHOLD;
        rstn_d   = 1'b0;
        cs_d     = 1'b0;
        ok_d     = 1'b0;
        fail_d   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TW'(RST_CYC - 1);
      end
      ST_RSTHOLD: if (tmr_zero) begin
        rstn_d = 1'b1;
        if (tgt_done) begin
          cs_d   = 1'b1;
          fail_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC - 1);
          st_d     = ST_SETTLE;
        end
      end
      ST_SETTLE: if (tmr_zero) begin
        cs_d     = 1'b1;
        sclk_d   = 1'b0;
        tmr_load = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = CW'(LEAD_CLKS);
        st_d     = ST_LEAD;
      end
      ST_LEAD, ST_TRAIL: if (tmr_zero) begin
        if (!sclk_q) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
        end else if (cnt_last) begin
          if (st_q == ST_LEAD) begin
            cs_d = 1'b0;
            st_d = ST_WAIT;
          end else begin
            ok_d   = tgt_done;
            fail_d = !tgt_done;
            st_d   = ST_IDLE;
          end
        end else begin
          cnt_dec  = 1'b1;
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
        end
      end
      ST_WAIT: if (byte_valid) begin
        ser_load = 1'b1;
        last_d   = byte_last;
        sclk_d   = 1'b0;
        tmr_load = 1'b1;
        st_d     = ST_SHIFT;
      end
      ST_SHIFT: if (tmr_zero) begin
        if (!sclk_q) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
        end else if (ser_empty) begin
          if (last_q) begin
            cs_d     = 1'b1;
            sclk_d   = 1'b0;
            tmr_load = 1'b1;
            cnt_load = 1'b1;
            cnt_val  = CW'(TRAIL_CLKS);
            st_d     = ST_TRAIL;
          end else begin
            st_d = ST_WAIT;
          end
        end else begin
          ser_shift = 1'b1;
          sclk_d    = 1'b0;
          tmr_load  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rstn_q <= 1'b1;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rstn_q <= rstn_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      ok_q   <= ok_d;
      fail_q <= fail_d;
      last_q <= last_d;
    end
  end

  assign tgt_rst_n  = rstn_q;
  assign tgt_cs_n   = cs_q;
  assign tgt_sclk   = sclk_q;
  assign tgt_mosi   = ser_mosi;
  assign busy       = (st_q != ST_IDLE);
  assign byte_ready = (st_q == ST_WAIT);
  assign load_ok    = ok_q;
  assign load_fail  = fail_q;

  p_rst_with_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !tgt_cs_n);
  p_runs_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD || st_q == ST_TRAIL) |-> tgt_cs_n);
  p_shift_cs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> (!tgt_cs_n && tgt_rst_n));
  p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sclk && $past(tgt_sclk)) |-> $stable(tgt_mosi));
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && load_fail));
  p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tgt_rst_n && tgt_cs_n && tgt_sclk));
  p_ready_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (tgt_sclk && !tgt_cs_n));
  p_busy_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/cfgseq_top_tb_top.sv
module cfgseq_top_tb_top;
  localparam int PERIOD  = 10;
  localparam int RST_CYC = 3;
  localparam int SET_CYC = 200;
  localparam int HALF    = 2;
  localparam int LEAD    = 8;
  localparam int TRAIL   = 49;

  // {nbytes[16:13], first byte[12:5], gap[4:1], done_ok[0]}
  localparam logic [16:0] VEC [4] = '{
    {4'd1, 8'hA5, 4'd0, 1'b1},
    {4'd3, 8'h3C, 4'd5, 1'b1},
    {4'd2, 8'hFF, 4'd9, 1'b0},
    {4'd4, 8'h01, 4'd1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic byte_valid = 1'b0, byte_last = 1'b0, tgt_done = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_mosi, busy, load_ok, load_fail;

  int checks = 0, fails = 0;
  logic mon_clr = 1'b0;
  int rlow, settle, lead, trail, low_run, half_err, hold_err, nrx, bitc, hs_cnt;
  logic seen_clk, prev_sclk, lastbit;
  logic [7:0] rxsh;
  logic [7:0] rx_mem [16];

  cfgseq_top #(
    .CLK_MHZ(10), .RST_HOLD_NS(300), .SETTLE_US(20), .SCLK_KHZ(2500),
    .LEAD_CLKS(LEAD), .TRAIL_CLKS(TRAIL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_last(byte_last), .byte_ready(byte_ready),
    .tgt_done(tgt_done), .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
    .tgt_sclk(tgt_sclk), .tgt_mosi(tgt_mosi), .busy(busy),
    .load_ok(load_ok), .load_fail(load_fail)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target-side monitor, sampled one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_clr) begin
      rlow = 0; settle = 0; lead = 0; trail = 0; low_run = 0; half_err = 0;
      hold_err = 0; nrx = 0; bitc = 0; hs_cnt = 0; seen_clk = 1'b0;
      prev_sclk = 1'b1; lastbit = 1'b0; rxsh = '0;
    end else begin
      if (!tgt_rst_n) rlow++;
      if (tgt_rst_n && !tgt_cs_n && !seen_clk) settle++;
      if (byte_ready && byte_valid) hs_cnt++;
      if (byte_ready && nrx > 0 && tgt_mosi != lastbit) hold_err++;
      if (!tgt_sclk) begin
        seen_clk = 1'b1;
        low_run++;
      end
      if (tgt_sclk && !prev_sclk) begin
        if (low_run != HALF) half_err++;
        low_run = 0;
        if (tgt_cs_n) begin
          if (nrx == 0 && bitc == 0) lead++;
          else trail++;
        end else begin
          rxsh = {rxsh[6:0], tgt_mosi};
          lastbit = tgt_mosi;
          bitc++;
          if (bitc == 8) begin
            rx_mem[nrx] = rxsh;
            nrx++;
            bitc = 0;
          end
        end
      end
      prev_sclk = tgt_sclk;
    end
  end

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  function automatic logic [7:0] byte_of(input logic [7:0] first, input int i);
    return first + 8'(i * 53);
  endfunction

  task automatic feed(input int n, input logic [7:0] first, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = byte_of(first, i);
      byte_last  = (i == n - 1);
      while (1) begin
        if (byte_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      byte_valid = 1'b0;
      byte_last  = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tgt_rst_n && tgt_cs_n && tgt_sclk && !busy, "R9 lines under reset",
        {tgt_rst_n, tgt_cs_n, tgt_sclk, busy}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!byte_ready && !load_ok && !load_fail, "R9 status after reset",
        {byte_ready, load_ok, load_fail}, 0);

    foreach (VEC[k]) begin
      int n; logic [7:0] first; int gap; logic ok;
      n = int'(VEC[k][16:13]); first = VEC[k][12:5];
      gap = int'(VEC[k][4:1]); ok = VEC[k][0];
      clear_mon();
      tgt_done = 1'b0;
      pulse_start();
      fork
        feed(n, first, gap);
        begin
          wait (tgt_rst_n == 1'b1);
          tgt_done = ok;
        end
        wait_idle();
      join
      @(negedge clk);
      chk(rlow == RST_CYC, "R1 reset hold cycles", rlow, RST_CYC);
      chk(settle == SET_CYC, "R3 settle cycles", settle, SET_CYC);
      chk(lead == LEAD, "R4 leading clocks", lead, LEAD);
      chk(nrx == n && bitc == 0, "R5 bytes received", nrx, n);
      for (int i = 0; i < n; i++)
        chk(rx_mem[i] == byte_of(first, i), "R5 byte value msb first",
            int'(rx_mem[i]), int'(byte_of(first, i)));
      chk(half_err == 0, "R6 low half length", half_err, 0);
      chk(trail == TRAIL, "R7 trailing clocks", trail, TRAIL);
      chk(load_ok == ok && load_fail == !ok, "R8 result flags",
          {load_ok, load_fail}, {ok, !ok});
      chk(tgt_rst_n && tgt_cs_n && tgt_sclk, "R9 lines after load",
          {tgt_rst_n, tgt_cs_n, tgt_sclk}, 3'b111);
      chk(hold_err == 0, "R10 data held while stalled", hold_err, 0);
      repeat (4) @(negedge clk);
      chk(load_ok == ok && load_fail == !ok, "R8 flags hold while idle",
          {load_ok, load_fail}, {ok, !ok});
    end

    // R2 done already high during reset hold
    clear_mon();
    tgt_done = 1'b1;
    byte_valid = 1'b1;
    byte_data = 8'h5A;
    pulse_start();
    wait_idle();
    @(negedge clk);
    chk(load_fail && !load_ok, "R2 early done fails", {load_ok, load_fail}, 2'b01);
    chk(rlow == RST_CYC, "R1 reset hold before early fail", rlow, RST_CYC);
    chk(!seen_clk && hs_cnt == 0, "R2 no clocks no handshake", hs_cnt, 0);
    chk(tgt_rst_n && tgt_cs_n, "R2 lines high after fail", {tgt_rst_n, tgt_cs_n}, 2'b11);
    byte_valid = 1'b0;
    tgt_done = 1'b0;

    // R9 reset in the middle of the data phase
    clear_mon();
    pulse_start();
    wait (byte_ready == 1'b1);
    @(negedge clk);
    chk(tgt_sclk && !tgt_cs_n, "R10 ready at boundary", {tgt_sclk, tgt_cs_n}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tgt_rst_n && tgt_cs_n && tgt_sclk && !busy && !byte_ready,
        "R9 lines after mid-run reset", {tgt_rst_n, tgt_cs_n, tgt_sclk, busy, byte_ready},
        5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule